// File: doc/BRIEF.md
# Periodic Interrupt and Square-Wave Generator

This block divides a 32768 Hz tick-enable into one of thirteen binary rates, from 8192 Hz down to 2 Hz. It uses the divided rate for two things: a square-wave output pin and a periodic event flag. A 4-bit rate code chooses the rate. Code 0 stops both. Codes 1 and 2 are aliases of two slower codes. An override bit sends the raw base tick to the square-wave pin and suppresses periodic events.

Software reaches four byte-wide registers through one write/read port: a rate register, an enable register, a status register and an extended register. A status read returns the periodic flag and a combined request bit, and the read clears both. The request bit also drives the interrupt output.

Top module: `rate_tick_gen`

## Requirements
- R1: After reset, all four registers read 0x00, `sqwOut` is 0 and `irqOut` is 0.
- R2: The register select values are 0 = rate register (bits 3:0 hold the rate code), 1 = enable register (bit 6 is the periodic interrupt enable, bit 3 is the square-wave enable), 2 = status register, and 3 = extended register (bit 6 is the override). Every bit not named here reads 0. Every named bit reads back the value last written.
- R3: For rate codes 3 to 15, a periodic event occurs once every 2^(code-1) ticks, counted from the last restart. Each event sets the periodic flag.
- R4: Rate code 1 behaves exactly like code 8 (period of 128 ticks). Rate code 2 behaves exactly like code 9 (period of 256 ticks).
- R5: With rate code 0, no periodic event occurs and `sqwOut` stays 0 while the override is clear.
- R6: When the square-wave enable is 1 and the override is 0, `sqwOut` is 0 for the first half of each period after a restart and 1 for the second half. When the square-wave enable is 0, `sqwOut` stays 0.
- R7: While the override bit is 1, `sqwOut` equals `tickEn` in the same cycle, whatever the square-wave enable is. No periodic events occur while the override is 1.
- R8: In the status register, bit 6 is the periodic flag and bit 7 is the AND of the flag and the periodic interrupt enable. Bits 5:0 read 0. `irqOut` equals bit 7. The flag sets even when the interrupt enable is 0.
- R9: A status read clears the periodic flag, and with it bit 7 and `irqOut`, at the clock edge of the read. If an event lands on that same edge, the flag stays set.
- R10: Writes to the status register have no effect.
- R11: A write to the rate register with a code different from the stored code restarts the period count from zero. A write of the same code leaves the count running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tickEn | input | 1 | One-cycle enable at 32768 Hz |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (status read clears flags) |
| regSel | input | 2 | Register select |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for the selected register (combinational) |
| sqwOut | output | 1 | Square-wave output |
| irqOut | output | 1 | Interrupt request |

## Verification
Random rate codes, including the two aliased codes, are run with random tick counts that fall before, at and after one full period. These runs separate correct period lengths from off-by-one wraps, and a correct half-period level from an inverted or shifted square wave. Random enable settings separate flag setting from interrupt gating. Directed cases cover the rest: the slowest code, code 0, the override, a write of the same code versus a different code partway through a period, and writes to the status register. These cases separate a correct restart and hold from a counter that runs on.

// File: rtl/rate_tick_pkg.sv
package rate_tick_pkg;
  localparam int RATE_W = 4;
  localparam int DATA_W = 8;
  localparam int SEL_W  = 2;
  localparam int CNT_W  = (1 << RATE_W) - 2;

  localparam logic [SEL_W-1:0] SEL_RATE = 2'd0;
  localparam logic [SEL_W-1:0] SEL_ENAB = 2'd1;
  localparam logic [SEL_W-1:0] SEL_STAT = 2'd2;
  localparam logic [SEL_W-1:0] SEL_EXT  = 2'd3;

  typedef struct packed {
    logic              restart;
    logic [RATE_W-1:0] rate;
    logic              sqwEn;
    logic              fastOut;
  } divCtl_t;

  function automatic logic [RATE_W-1:0] effRate(input logic [RATE_W-1:0] code);
    case (code)
      4'd1:    return 4'd8;
      4'd2:    return 4'd9;
      default: return code;
    endcase
  endfunction
endpackage

// File: rtl/rate_tick_div.sv
module rate_tick_div
  import rate_tick_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    tickEn,
  input  divCtl_t ctl,
  output logic    periodTick,
  output logic    sqwOut
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] periodLast;
  logic [RATE_W-1:0] halfIdx;
  logic rateOn;
  logic wrapNow;

  assign rateOn     = (ctl.rate != '0);
  assign periodLast = rateOn ? CNT_W'((32'd1 << (ctl.rate - 4'd1)) - 32'd1) : '0;
  assign halfIdx    = (ctl.rate >= 4'd2) ? (ctl.rate - 4'd2) : '0;
  assign wrapNow    = tickEn && rateOn && (cnt == periodLast);
  assign periodTick = wrapNow && !ctl.fastOut;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt <= '0;
    else if (ctl.restart || !rateOn) cnt <= '0;
    else if (wrapNow)              cnt <= '0;
    else if (tickEn)               cnt <= cnt + 1'b1;
  end

  always_comb begin
    if (ctl.fastOut)                   sqwOut = tickEn;
    else if (ctl.sqwEn && rateOn)      sqwOut = cnt[halfIdx];
    else                               sqwOut = 1'b0;
  end

  p_restart_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.restart |=> (cnt == '0));
  p_fast_noev_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ctl.fastOut |-> !periodTick);
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= periodLast || ctl.restart || $changed(ctl.rate));
  p_cnt_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.rate == '0) |=> (cnt == '0));
endmodule

// File: rtl/rate_tick_ctrl.sv
module rate_tick_ctrl
  import rate_tick_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [SEL_W-1:0]  regSel,
  input  logic [DATA_W-1:0] wrData,
  input  logic              periodTick,
  output logic [DATA_W-1:0] rdData,
  output logic              irqOut,
  output divCtl_t           ctl
);
  logic [RATE_W-1:0] rateQ;
  logic pieQ, sqweQ, fastQ, pfQ;
  logic wrRate, wrEnab, wrExt, rdStat;
  logic unusedWr;

  assign unusedWr = ^{wrData[7], wrData[5:4]};
  assign wrRate = wrEn && (regSel == SEL_RATE);
  assign wrEnab = wrEn && (regSel == SEL_ENAB);
  assign wrExt  = wrEn && (regSel == SEL_EXT);
  assign rdStat = rdEn && (regSel == SEL_STAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rateQ <= '0;
      pieQ  <= 1'b0;
      sqweQ <= 1'b0;
      fastQ <= 1'b0;
    end else begin
      if (wrRate) rateQ <= wrData[RATE_W-1:0];
      if (wrEnab) begin
        pieQ  <= wrData[6];
        sqweQ <= wrData[3];
      end
      if (wrExt) fastQ <= wrData[6];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          pfQ <= 1'b0;
    else if (periodTick) pfQ <= 1'b1;
    else if (rdStat)     pfQ <= 1'b0;
  end

  assign irqOut = pfQ && pieQ;

  assign ctl.restart = wrRate && (wrData[RATE_W-1:0] != rateQ);
  assign ctl.rate    = effRate(rateQ);
  assign ctl.sqwEn   = sqweQ;
  assign ctl.fastOut = fastQ;

  always_comb begin
    rdData = '0;
    case (regSel)
      SEL_RATE: rdData[RATE_W-1:0] = rateQ;
      SEL_ENAB: begin rdData[6] = pieQ; rdData[3] = sqweQ; end
      SEL_STAT: begin rdData[7] = irqOut; rdData[6] = pfQ; end
      default:  rdData[6] = fastQ;
    endcase
  end

  p_rdclr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rdStat && !periodTick) |=> !pfQ);
  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    periodTick |=> pfQ);
  p_flag_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!pfQ && !periodTick) |=> !pfQ);
endmodule

// File: rtl/rate_tick_gen.sv
module rate_tick_gen
  import rate_tick_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tickEn,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [SEL_W-1:0]  regSel,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic              sqwOut,
  output logic              irqOut
);
  divCtl_t ctl;
  logic periodTick;

  rate_tick_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .rdEn(rdEn), .regSel(regSel),
    .wrData(wrData), .periodTick(periodTick), .rdData(rdData),
    .irqOut(irqOut), .ctl(ctl)
  );

  rate_tick_div u_div (
    .clk(clk), .rst_n(rst_n), .tickEn(tickEn), .ctl(ctl),
    .periodTick(periodTick), .sqwOut(sqwOut)
  );
endmodule

// File: tb/rate_tick_gen_bench.sv
module rate_tick_gen_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, tickEn = 1'b0, wrEn = 1'b0, rdEn = 1'b0;
  logic [1:0] regSel = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic sqwOut, irqOut;
  int nChecks = 0, nErr = 0;

  rate_tick_gen u_rate_tick_gen (
    .clk(clk), .rst_n(rst_n), .tickEn(tickEn), .wrEn(wrEn), .rdEn(rdEn),
    .regSel(regSel), .wrData(wrData), .rdData(rdData),
    .sqwOut(sqwOut), .irqOut(irqOut)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int periodOf(input int code);
    int e;
    e = (code == 1) ? 8 : (code == 2) ? 9 : code;
    return (e == 0) ? 0 : (1 << (e - 1));
  endfunction

  task automatic check(input int act, input int exp, input string tag);
    nChecks++;
    if (act != exp) begin
      nErr++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk); wrEn = 1'b1; regSel = sel; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [7:0] d);
    @(negedge clk); rdEn = 1'b1; regSel = sel; #1 d = rdData;
    @(negedge clk); rdEn = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tickEn = 1'b1;
      @(negedge clk); tickEn = 1'b0;
    end
  endtask

  task automatic startCode(input int code);
    logic [7:0] d;
    wr(2'd0, 8'h00);
    wr(2'd0, 8'(code));
    rd(2'd2, d);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nErr++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int s = 0; s < 4; s++) begin rd(2'(s), d); check(d, 0, "R1 reg reset"); end
    check(sqwOut, 0, "R1 sqwOut"); check(irqOut, 0, "R1 irqOut");

    // R2 readback with unused bits masked
    wr(2'd0, 8'hFB); rd(2'd0, d); check(d, 8'h0B, "R2 rate readback");
    wr(2'd1, 8'hFF); rd(2'd1, d); check(d, 8'h48, "R2 enable readback");
    wr(2'd3, 8'hFF); rd(2'd3, d); check(d, 8'h40, "R2 ext readback");
    wr(2'd3, 8'h00); wr(2'd1, 8'h00);

    // R3 R4 R6 R8 random rates and tick counts
    for (int it = 0; it < 30; it++) begin
      int code, per, n;
      logic pie, sqe, pf;
      code = int'($urandom_range(1, 10));
      per  = periodOf(code);
      pie  = 1'($urandom_range(0, 1));
      sqe  = 1'($urandom_range(0, 1));
      n    = int'($urandom_range(0, 2 * per));
      if (it == 0) n = per - 1;
      if (it == 1) n = per;
      wr(2'd1, {1'b0, pie, 2'b0, sqe, 3'b0});
      startCode(code);
      ticks(n);
      pf = (n >= per);
      #1;
      check(sqwOut, int'(sqe && ((n % per) >= per / 2)), "R6 square level");
      check(irqOut, int'(pf && pie), "R8 irqOut");
      rd(2'd2, d);
      check(d, {pf && pie, pf, 6'b0}, (code <= 2) ? "R4 alias status" : "R3 status");
      rd(2'd2, d);
      check(d, 0, "R9 cleared after read");
    end

    // R3 slowest code
    wr(2'd1, 8'h40);
    startCode(15);
    ticks(16383); rd(2'd2, d); check(d, 8'h00, "R3 code15 before");
    ticks(1);     rd(2'd2, d); check(d, 8'hC0, "R3 code15 at period");

    // R4 explicit alias edge
    startCode(2);
    ticks(255); rd(2'd2, d); check(d, 8'h00, "R4 code2 before");
    ticks(1);   rd(2'd2, d); check(d, 8'hC0, "R4 code2 at 256");

    // R5 code 0
    wr(2'd1, 8'h48); startCode(0);
    ticks(300); #1 check(sqwOut, 0, "R5 sqw low");
    rd(2'd2, d); check(d, 0, "R5 no flag");

    // R8 flag without enable
    wr(2'd1, 8'h00); startCode(3);
    ticks(4); #1 check(irqOut, 0, "R8 irq gated");
    rd(2'd2, d); check(d, 8'h40, "R8 flag without enable");

    // R7 override
    wr(2'd3, 8'h40);
    @(negedge clk); tickEn = 1'b1; #1 check(sqwOut, 1, "R7 follows tick high");
    @(negedge clk); tickEn = 1'b0; #1 check(sqwOut, 0, "R7 follows tick low");
    ticks(20); rd(2'd2, d); check(d, 0, "R7 no events");
    wr(2'd3, 8'h00);

    // R10 writes to status ignored
    startCode(3); ticks(4);
    wr(2'd2, 8'h00); rd(2'd2, d); check(d, 8'h40, "R10 write ignored");
    wr(2'd2, 8'hFF); rd(2'd2, d); check(d, 8'h00, "R10 no set by write");

    // R11 same code keeps count, new code restarts
    startCode(4);
    ticks(5); wr(2'd0, 8'h04); ticks(3);
    rd(2'd2, d); check(d, 8'h40, "R11 same code no restart");
    ticks(5); wr(2'd0, 8'h05); ticks(8);
    rd(2'd2, d); check(d, 8'h00, "R11 restart before");
    ticks(8); rd(2'd2, d); check(d, 8'h40, "R11 restart at period");

    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end
endmodule